// File: doc/BRIEF.md
# AXI4 to TileLink Uncached Request/Response Bridge

This block lets an AXI4 master that issues only single-beat transactions talk to a TileLink Uncached slave. The AXI read-address channel becomes a TileLink Get. An AW beat paired with a W beat becomes a PutFullData or a PutPartialData message. Both kinds of request share one TileLink A channel, so a small round-robin arbiter takes turns between them.

Responses return on the TileLink D channel. A response that carries data goes back on AXI R. A response without data goes back on AXI B. The outgoing source ID is the AXI ID with one extra bit at the bottom: 0 marks a read and 1 marks a write. The AXI ID is recovered from the D source by dropping that bit.

The arbiter is a four-state machine:
- `ST_FAVOR_RD` offers the A channel to the read path first.
- `ST_FAVOR_WR` offers it to the write path first.
- `ST_HOLD_RD` and `ST_HOLD_WR` keep a grant that was issued but not yet accepted.

Its transitions are:
- From a favour state, an accepted read goes to `ST_FAVOR_WR`. An accepted write goes to `ST_FAVOR_RD`.
- From a favour state, a granted request that is stalled by A-ready low goes to the matching hold state.
- A hold state returns to the opposite favour state on the cycle A-ready is high.
- With no request pending, the state is unchanged.
- Reset enters `ST_FAVOR_RD`.

Top module: `axi2tl_bridge`

## Requirements
- R1: After reset (rst_n low is synchronous-reset, active low), with no input valid, `a_valid`, `r_valid` and `b_valid` are low. The first arbitration favours the read path: when a read and a write are both pending, the read is granted.
- R2: A granted read drives the A channel as follows:
  - `a_valid` equals `ar_valid`.
  - `a_opcode` is 4 (Get) and `a_data` is 0.
  - `a_source` is `{ar_id, 1'b0}`.
  - `a_address` is `ar_addr` and `a_size` is `ar_size`.
  - `a_mask` bit i is set when, for every lane-index bit k at or above `ar_size`, bit k of i equals bit k of `ar_addr`.
  - `ar_ready` equals `a_ready` while the read holds the grant.
- R3: A write is presented on A only while `aw_valid` and `w_valid` are both high. Its fields are:
  - `a_source` is `{aw_id, 1'b1}`.
  - `a_data` is `w_data` and `a_mask` is `w_strb`.
  - `a_address` is `aw_addr` and `a_size` is `aw_size`.
- R4: A write's `a_opcode` is 0 (PutFullData) when every `w_strb` bit is set. Otherwise it is 1 (PutPartialData).
- R5: `aw_ready` is high only when the write path holds the grant, `a_ready` is high, `w_valid` is high and `w_last` is high. `w_ready` is high when the write path holds the grant, `a_ready` is high and `aw_valid` is high.
- R6: When both paths request, grants alternate. After an accepted read the write wins next, and after an accepted write the read wins next.
- R7: A grant given to a request that A does not accept stays with that request until `a_ready` is high. Over those cycles `a_source`, `a_address` and `a_opcode` are unchanged.
- R8: A D beat whose `d_opcode` is 1 (AccessAckData) raises `r_valid`. Any other opcode raises `b_valid`. `d_ready` equals `r_ready` or `b_ready` for the selected side. `r_valid` and `b_valid` are never high together.
- R9: `r_id` and `b_id` equal `d_source` shifted right by one. `r_data` equals `d_data`. `r_last` is high with every R beat.
- R10: `r_resp` and `b_resp` are 2 (SLVERR) when `d_denied` or `d_corrupt` is set, and 0 (OKAY) otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address accepted |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read byte address |
| ar_size | input | SIZE_W | Read size, log2 bytes |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address accepted |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write byte address |
| aw_size | input | SIZE_W | Write size, log2 bytes |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Write byte strobes |
| w_last | input | 1 | Last write beat |
| r_valid | output | 1 | Read response valid |
| r_ready | input | 1 | Read response accepted |
| r_id | output | ID_W | Read response ID |
| r_data | output | DATA_W | Read data |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Last read beat, always high |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response accepted |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response code |
| a_valid | output | 1 | TileLink request valid |
| a_ready | input | 1 | TileLink request accepted |
| a_opcode | output | 3 | Request opcode |
| a_size | output | SIZE_W | Request size |
| a_source | output | ID_W+1 | Request source ID |
| a_address | output | ADDR_W | Request address |
| a_mask | output | DATA_W/8 | Request byte mask |
| a_data | output | DATA_W | Request data |
| d_valid | input | 1 | TileLink response valid |
| d_ready | output | 1 | TileLink response accepted |
| d_opcode | input | 3 | Response opcode |
| d_source | input | ID_W+1 | Response source ID |
| d_denied | input | 1 | Response denied flag |
| d_corrupt | input | 1 | Response corrupt flag |
| d_data | input | DATA_W | Response data |

## Verification
The only state in the block is the arbiter's state register. A wrong state shows at the A port on the very next cycle in which both paths request. It can show as a grant to the same side twice in a row, as a grant that moves away from a stalled request, or as a write-path ready pulse with no write on A.

The bench runs a behavioural turn-and-hold model that is independent of the RTL. It compares every A, AW, W, R, B and D output against that model on every cycle. A state fault is therefore reported within one cycle of the first contested or stalled request. Random traffic with A-ready frequently low produces such requests within a few cycles.

// File: rtl/axi2tl_pkg.sv
package axi2tl_pkg;

    localparam logic [2:0] TL_A_PUT_FULL  = 3'd0;
    localparam logic [2:0] TL_A_PUT_PART  = 3'd1;
    localparam logic [2:0] TL_A_GET       = 3'd4;
    localparam logic [2:0] TL_D_ACK_DATA  = 3'd1;

    localparam logic [1:0] AXI_RESP_OKAY   = 2'b00;
    localparam logic [1:0] AXI_RESP_SLVERR = 2'b10;

    typedef enum logic [1:0] {
        ST_FAVOR_RD = 2'd0,
        ST_FAVOR_WR = 2'd1,
        ST_HOLD_RD  = 2'd2,
        ST_HOLD_WR  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/axi2tl_get_fmt.sv
module axi2tl_get_fmt #(
    parameter int ID_W   = 4,
    parameter int SIZE_W = 3,
    parameter int STRB_W = 4,
    parameter int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1
) (
    input  logic [ID_W-1:0]   rd_id,
    input  logic [LANE_W-1:0] rd_lane,
    input  logic [SIZE_W-1:0] rd_size,
    output logic [ID_W:0]     get_source,
    output logic [STRB_W-1:0] get_mask
);

    assign get_source = {rd_id, 1'b0};

    // A lane is enabled when its index agrees with the address on every
    // lane-index bit that the transfer size does not cover.
    logic [LANE_W-1:0] lane_idx;
    logic              lane_hit;

    always_comb begin
        get_mask = '0;
        lane_idx = '0;
        lane_hit = 1'b0;
        for (int i = 0; i < STRB_W; i++) begin
            lane_idx = LANE_W'(i);
            lane_hit = 1'b1;
            for (int k = 0; k < LANE_W; k++) begin
                if ((32'(k) >= 32'(rd_size)) && (lane_idx[k] != rd_lane[k])) begin
                    lane_hit = 1'b0;
                end
            end
            get_mask[i] = lane_hit;
        end
    end

endmodule

// File: rtl/axi2tl_put_fmt.sv
module axi2tl_put_fmt #(
    parameter int ID_W   = 4,
    parameter int STRB_W = 4
) (
    input  logic [ID_W-1:0]   wr_id,
    input  logic [STRB_W-1:0] wr_strb,
    output logic [ID_W:0]     put_source,
    output logic [2:0]        put_opcode
);
    import axi2tl_pkg::*;

    assign put_source = {wr_id, 1'b1};
    assign put_opcode = (&wr_strb) ? TL_A_PUT_FULL : TL_A_PUT_PART;

endmodule

// File: rtl/axi2tl_rr_arb.sv
module axi2tl_rr_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic out_ready,
    output logic gnt_rd,
    output logic gnt_wr
);
    import axi2tl_pkg::*;

    arb_state_e state_q;
    arb_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FAVOR_RD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        gnt_rd  = 1'b0;
        gnt_wr  = 1'b0;
        unique case (state_q)
            ST_FAVOR_RD: begin
                if (rd_req)      gnt_rd = 1'b1;
                else if (wr_req) gnt_wr = 1'b1;
            end
            ST_FAVOR_WR: begin
                if (wr_req)      gnt_wr = 1'b1;
                else if (rd_req) gnt_rd = 1'b1;
            end
            ST_HOLD_RD: gnt_rd = 1'b1;
            ST_HOLD_WR: gnt_wr = 1'b1;
            default: begin
                gnt_rd = 1'b0;
                gnt_wr = 1'b0;
            end
        endcase

        state_d = state_q;
        if (gnt_rd) begin
            state_d = out_ready ? ST_FAVOR_WR : ST_HOLD_RD;
        end else if (gnt_wr) begin
            state_d = out_ready ? ST_FAVOR_RD : ST_HOLD_WR;
        end
    end

endmodule

// File: rtl/axi2tl_resp_route.sv
module axi2tl_resp_route #(
    parameter int ID_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic              d_valid,
    output logic              d_ready,
    input  logic [2:0]        d_opcode,
    input  logic [ID_W-1:0]   d_id,
    input  logic              d_denied,
    input  logic              d_corrupt,
    input  logic [DATA_W-1:0] d_data,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [ID_W-1:0]   r_id,
    output logic [DATA_W-1:0] r_data,
    output logic [1:0]        r_resp,
    output logic              r_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [1:0]        b_resp
);
    import axi2tl_pkg::*;

    logic       carries_data;
    logic [1:0] resp_code;

    assign carries_data = (d_opcode == TL_D_ACK_DATA);
    assign resp_code    = (d_denied || d_corrupt) ? AXI_RESP_SLVERR : AXI_RESP_OKAY;

    assign r_valid = d_valid && carries_data;
    assign b_valid = d_valid && !carries_data;
    assign d_ready = carries_data ? r_ready : b_ready;

    assign r_id   = d_id;
    assign r_data = d_data;
    assign r_resp = resp_code;
    assign r_last = 1'b1;
    assign b_id   = d_id;
    assign b_resp = resp_code;

endmodule

// File: rtl/axi2tl_bridge.sv
module axi2tl_bridge #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3,
    localparam int STRB_W = DATA_W / 8,
    localparam int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1,
    localparam int SRC_W  = ID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid,
    output logic              ar_ready,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [SIZE_W-1:0] ar_size,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [SIZE_W-1:0] aw_size,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic [STRB_W-1:0] w_strb,
    input  logic              w_last,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [ID_W-1:0]   r_id,
    output logic [DATA_W-1:0] r_data,
    output logic [1:0]        r_resp,
    output logic              r_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [1:0]        b_resp,
    output logic              a_valid,
    input  logic              a_ready,
    output logic [2:0]        a_opcode,
    output logic [SIZE_W-1:0] a_size,
    output logic [SRC_W-1:0]  a_source,
    output logic [ADDR_W-1:0] a_address,
    output logic [STRB_W-1:0] a_mask,
    output logic [DATA_W-1:0] a_data,
    input  logic              d_valid,
    output logic              d_ready,
    input  logic [2:0]        d_opcode,
    input  logic [SRC_W-1:0]  d_source,
    input  logic              d_denied,
    input  logic              d_corrupt,
    input  logic [DATA_W-1:0] d_data
);
    import axi2tl_pkg::*;

    logic              wr_pair;
    logic              gnt_rd;
    logic              gnt_wr;
    logic [SRC_W-1:0]  get_source;
    logic [STRB_W-1:0] get_mask;
    logic [SRC_W-1:0]  put_source;
    logic [2:0]        put_opcode;
    logic              unused_dir_flag;

    assign wr_pair = aw_valid && w_valid;

    axi2tl_get_fmt #(
        .ID_W   (ID_W),
        .SIZE_W (SIZE_W),
        .STRB_W (STRB_W),
        .LANE_W (LANE_W)
    ) u_get (
        .rd_id      (ar_id),
        .rd_lane    (ar_addr[LANE_W-1:0]),
        .rd_size    (ar_size),
        .get_source (get_source),
        .get_mask   (get_mask)
    );

    axi2tl_put_fmt #(
        .ID_W   (ID_W),
        .STRB_W (STRB_W)
    ) u_put (
        .wr_id      (aw_id),
        .wr_strb    (w_strb),
        .put_source (put_source),
        .put_opcode (put_opcode)
    );

    axi2tl_rr_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (ar_valid),
        .wr_req    (wr_pair),
        .out_ready (a_ready),
        .gnt_rd    (gnt_rd),
        .gnt_wr    (gnt_wr)
    );

    assign a_valid   = (gnt_rd && ar_valid) || (gnt_wr && wr_pair);
    assign a_opcode  = gnt_wr ? put_opcode : TL_A_GET;
    assign a_size    = gnt_wr ? aw_size    : ar_size;
    assign a_source  = gnt_wr ? put_source : get_source;
    assign a_address = gnt_wr ? aw_addr    : ar_addr;
    assign a_mask    = gnt_wr ? w_strb     : get_mask;
    assign a_data    = gnt_wr ? w_data     : '0;

    assign ar_ready = gnt_rd && a_ready;
    assign aw_ready = gnt_wr && a_ready && w_valid && w_last;
    assign w_ready  = gnt_wr && a_ready && aw_valid;

    assign unused_dir_flag = d_source[0];

    axi2tl_resp_route #(
        .ID_W   (ID_W),
        .DATA_W (DATA_W)
    ) u_resp (
        .d_valid   (d_valid),
        .d_ready   (d_ready),
        .d_opcode  (d_opcode),
        .d_id      (d_source[SRC_W-1:1]),
        .d_denied  (d_denied),
        .d_corrupt (d_corrupt),
        .d_data    (d_data),
        .r_valid   (r_valid),
        .r_ready   (r_ready),
        .r_id      (r_id),
        .r_data    (r_data),
        .r_resp    (r_resp),
        .r_last    (r_last),
        .b_valid   (b_valid),
        .b_ready   (b_ready),
        .b_id      (b_id),
        .b_resp    (b_resp)
    );

endmodule

// File: rtl/axi2tl_bridge_chk.sv
module axi2tl_bridge_chk #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ar_valid,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic              w_valid,
    input logic              w_last,
    input logic              r_valid,
    input logic              r_ready,
    input logic [ID_W-1:0]   r_id,
    input logic [1:0]        r_resp,
    input logic              r_last,
    input logic              b_valid,
    input logic              a_valid,
    input logic              a_ready,
    input logic [2:0]        a_opcode,
    input logic [ID_W:0]     a_source,
    input logic [ADDR_W-1:0] a_address,
    input logic              d_valid,
    input logic              d_ready,
    input logic [2:0]        d_opcode,
    input logic [ID_W:0]     d_source,
    input logic              d_denied,
    input logic              d_corrupt
);

    a_r3_write_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_source[0]) |-> (aw_valid && w_valid));

    a_r5_aw_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        aw_ready |-> (w_valid && w_last && a_ready && a_valid));

    a_r6_read_yields: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready && !a_source[0]) |=>
            (!(ar_valid && aw_valid && w_valid) || a_source[0]));

    a_r6_write_yields: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready && a_source[0]) |=>
            (!(ar_valid && aw_valid && w_valid) || !a_source[0]));

    a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !a_ready) |=>
            (a_valid && $stable(a_source) && $stable(a_address) && $stable(a_opcode)));

    a_r8_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_valid && b_valid));

    a_r8_ready_follows_r: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_opcode == 3'd1) |-> (d_ready == r_ready));

    a_r9_id_and_last: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> (r_last && r_id == d_source[ID_W:1]));

    a_r10_error_map: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && (d_denied || d_corrupt)) |-> (r_resp == 2'b10));

endmodule

bind axi2tl_bridge axi2tl_bridge_chk #(
    .ID_W   (ID_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/tb_axi2tl_bridge.sv
module tb_axi2tl_bridge;

    localparam int ID_W   = 4;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 3;
    localparam int STRB_W = DATA_W / 8;
    localparam int SRC_W  = ID_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ar_valid = 0, ar_ready;
    logic [ID_W-1:0]   ar_id = '0;
    logic [ADDR_W-1:0] ar_addr = '0;
    logic [SIZE_W-1:0] ar_size = '0;
    logic              aw_valid = 0, aw_ready;
    logic [ID_W-1:0]   aw_id = '0;
    logic [ADDR_W-1:0] aw_addr = '0;
    logic [SIZE_W-1:0] aw_size = '0;
    logic              w_valid = 0, w_ready;
    logic [DATA_W-1:0] w_data = '0;
    logic [STRB_W-1:0] w_strb = '0;
    logic              w_last = 0;
    logic              r_valid, r_ready = 0, r_last;
    logic [ID_W-1:0]   r_id;
    logic [DATA_W-1:0] r_data;
    logic [1:0]        r_resp;
    logic              b_valid, b_ready = 0;
    logic [ID_W-1:0]   b_id;
    logic [1:0]        b_resp;
    logic              a_valid, a_ready = 0;
    logic [2:0]        a_opcode;
    logic [SIZE_W-1:0] a_size;
    logic [SRC_W-1:0]  a_source;
    logic [ADDR_W-1:0] a_address;
    logic [STRB_W-1:0] a_mask;
    logic [DATA_W-1:0] a_data;
    logic              d_valid = 0, d_ready;
    logic [2:0]        d_opcode = '0;
    logic [SRC_W-1:0]  d_source = '0;
    logic              d_denied = 0, d_corrupt = 0;
    logic [DATA_W-1:0] d_data = '0;

    always #2 clk = ~clk;

    axi2tl_bridge #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) dut (.*);

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;
    bit  ar_fired = 0;
    bit  wr_fired = 0;
    int  favor_wr = 0;
    int  held     = -1;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [STRB_W-1:0] lanes_for(input logic [ADDR_W-1:0] addr,
                                                    input logic [SIZE_W-1:0] size);
        logic [STRB_W-1:0] m;
        int span;
        span = 1 << size;
        for (int i = 0; i < STRB_W; i++) begin
            m[i] = (((i ^ int'(addr[1:0])) & ~(span - 1)) == 0);
        end
        return m;
    endfunction

    // Reference model: a turn pointer and a held side, checked every cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            favor_wr = 0;
            held     = -1;
        end else begin
            int  winner;
            bit  wr_v;
            bit  exp_av;
            bit  has_data;
            wr_v = aw_valid && w_valid;
            if (held >= 0)                 winner = held;
            else if (favor_wr == 0)        winner = ar_valid ? 0 : (wr_v ? 1 : -1);
            else                           winner = wr_v ? 1 : (ar_valid ? 0 : -1);
            exp_av = (winner == 0) ? ar_valid : ((winner == 1) ? wr_v : 1'b0);

            chk("R6", "a_valid", 64'(a_valid), 64'(exp_av));
            chk("R2", "ar_ready", 64'(ar_ready), 64'(a_ready && winner == 0));
            chk("R5", "aw_ready", 64'(aw_ready), 64'(a_ready && winner == 1 && w_valid && w_last));
            chk("R5", "w_ready", 64'(w_ready), 64'(a_ready && winner == 1 && aw_valid));
            if (exp_av && winner == 0) begin
                chk("R2", "get opcode", 64'(a_opcode), 64'd4);
                chk("R2", "get source", 64'(a_source), 64'({ar_id, 1'b0}));
                chk("R2", "get address", 64'(a_address), 64'(ar_addr));
                chk("R2", "get size", 64'(a_size), 64'(ar_size));
                chk("R2", "get mask", 64'(a_mask), 64'(lanes_for(ar_addr, ar_size)));
                chk("R2", "get data", 64'(a_data), 64'd0);
            end else if (exp_av) begin
                chk("R4", "put opcode", 64'(a_opcode), (w_strb == '1) ? 64'd0 : 64'd1);
                chk("R3", "put source", 64'(a_source), 64'({aw_id, 1'b1}));
                chk("R3", "put address", 64'(a_address), 64'(aw_addr));
                chk("R3", "put size", 64'(a_size), 64'(aw_size));
                chk("R3", "put mask", 64'(a_mask), 64'(w_strb));
                chk("R3", "put data", 64'(a_data), 64'(w_data));
            end

            has_data = (d_opcode == 3'd1);
            chk("R8", "r_valid", 64'(r_valid), 64'(d_valid && has_data));
            chk("R8", "b_valid", 64'(b_valid), 64'(d_valid && !has_data));
            chk("R8", "d_ready", 64'(d_ready), 64'(has_data ? r_ready : b_ready));
            if (d_valid) begin
                chk("R9", "r_id", 64'(r_id), 64'(d_source >> 1));
                chk("R9", "b_id", 64'(b_id), 64'(d_source >> 1));
                chk("R9", "r_data", 64'(r_data), 64'(d_data));
                chk("R9", "r_last", 64'(r_last), 64'd1);
                chk("R10", "r_resp", 64'(r_resp), (d_denied || d_corrupt) ? 64'd2 : 64'd0);
                chk("R10", "b_resp", 64'(b_resp), (d_denied || d_corrupt) ? 64'd2 : 64'd0);
            end

            ar_fired = ar_valid && ar_ready;
            wr_fired = aw_valid && aw_ready;
            if (winner >= 0) begin
                if (a_ready) begin
                    favor_wr = 1 - winner;
                    held     = -1;
                end else begin
                    held = winner;
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        ar_valid = 0; aw_valid = 0; w_valid = 0; w_last = 0;
        a_ready = 0; d_valid = 0; r_ready = 0; b_ready = 0;
        d_denied = 0; d_corrupt = 0;
    endtask

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset a_valid", 64'(a_valid), 64'd0);
        chk("R1", "reset r_valid", 64'(r_valid), 64'd0);
        chk("R1", "reset b_valid", 64'(b_valid), 64'd0);
        step();
        rst_n = 1;

        // R1 / R6 / R7: contested start, stalled, then alternating grants
        ar_valid = 1; ar_id = 4'd3; ar_addr = 32'h100; ar_size = 3'd2;
        aw_valid = 1; w_valid = 1; w_last = 1; aw_id = 4'd5; aw_addr = 32'h204;
        aw_size = 3'd2; w_data = 32'hCAFE_0001; w_strb = 4'hF; a_ready = 0;
        @(negedge clk);
        chk("R1", "first grant to read", 64'(a_source), 64'h6);
        step();
        @(negedge clk);
        chk("R7", "stalled source held", 64'(a_source), 64'h6);
        step();
        a_ready = 1;
        @(negedge clk);
        chk("R2", "read accepted", 64'(ar_ready), 64'd1);
        step();
        ar_valid = 0;
        @(negedge clk);
        chk("R6", "write after read", 64'(a_source), 64'hB);
        chk("R4", "full put opcode", 64'(a_opcode), 64'd0);
        step();
        clear_all();

        // R5: W beat without last is taken, AW is not
        aw_valid = 1; w_valid = 1; w_last = 0; a_ready = 1;
        @(negedge clk);
        chk("R5", "w_ready without last", 64'(w_ready), 64'd1);
        chk("R5", "aw_ready without last", 64'(aw_ready), 64'd0);
        step();
        clear_all();

        // R4: partial strobe
        aw_valid = 1; w_valid = 1; w_last = 1; w_strb = 4'b0011; a_ready = 1;
        @(negedge clk);
        chk("R4", "partial put opcode", 64'(a_opcode), 64'd1);
        chk("R3", "partial put mask", 64'(a_mask), 64'h3);
        step();
        clear_all();

        // R8 / R9 / R10: responses
        d_valid = 1; d_opcode = 3'd1; d_source = 5'd14; d_denied = 1;
        d_data = 32'h1234_5678; r_ready = 1;
        @(negedge clk);
        chk("R10", "denied gives slverr", 64'(r_resp), 64'd2);
        chk("R9", "id recovered", 64'(r_id), 64'd7);
        chk("R8", "d_ready from r", 64'(d_ready), 64'd1);
        step();
        d_opcode = 3'd0; d_denied = 0; d_corrupt = 0; b_ready = 0; d_source = 5'd9;
        @(negedge clk);
        chk("R8", "ack goes to b", 64'(b_valid), 64'd1);
        chk("R10", "clean ack okay", 64'(b_resp), 64'd0);
        chk("R8", "d_ready from b", 64'(d_ready), 64'd0);
        step();
        clear_all();

        // Mixed traffic with masters holding stalled requests
        for (int c = 0; c < 4000; c++) begin
            step();
            if (!ar_valid || ar_fired) begin
                ar_valid = 1'($urandom % 2);
                ar_id    = ID_W'($urandom);
                ar_addr  = ADDR_W'($urandom);
                ar_size  = SIZE_W'($urandom % 3);
            end
            if (!(aw_valid && w_valid) || wr_fired) begin
                aw_valid = 1'($urandom % 2);
                w_valid  = 1'($urandom % 2);
                w_last   = 1'b1;
                aw_id    = ID_W'($urandom);
                aw_addr  = ADDR_W'($urandom);
                aw_size  = SIZE_W'($urandom % 3);
                w_data   = DATA_W'($urandom);
                w_strb   = ($urandom % 3 == 0) ? '1 : STRB_W'($urandom);
            end
            a_ready   = ($urandom % 4) != 0;
            r_ready   = 1'($urandom % 2);
            b_ready   = 1'($urandom % 2);
            d_valid   = 1'($urandom % 2);
            d_opcode  = 3'($urandom % 2);
            d_source  = SRC_W'($urandom);
            d_denied  = ($urandom % 8) == 0;
            d_corrupt = ($urandom % 8) == 0;
            d_data    = DATA_W'($urandom);
        end
        step();
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired before the run ended");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule